// File: doc/BRIEF.md
# Successive-Approximation Register, Resettable Cascade Stage

This block holds and steers the digital side of a successive-approximation converter. After a start it tries one bit per clock, most significant first. It sets the trial bit high. On the next clock it keeps or drops that bit according to a one-bit comparator verdict, and it sets the next lower bit as the new trial. The parallel word is meant to drive a DAC.

The same bit decisions leave the block one at a time on a serial output. An end-of-conversion flag rises half a clock after the last bit is decided. This gives downstream logic a settled word and a clean edge or level to act on.

The block is built to sit behind another converter stage. A synchronous master reset clears it. It then stays cleared while its start input is low, so a front stage can hold it parked and later launch it. A start is recognised on a rising start input, or on the first clock after the master reset is released while the start input is high. The word width is a parameter, 8 by default.

Top module: `sar_cascade_reg`

## Requirements
- R1: When `mr_i` is 1 at a rising clock edge, `q_o` becomes all zeros and `sout_o` becomes 0 at that edge, whatever `sc_i` is. `eoc_o` is 0 from the following falling edge.
- R2: A start occurs at a rising edge where `sc_i`=1 and `mr_i`=0, and where either `sc_i` was 0 or `mr_i` was 1 at the previous rising edge. After that edge `q_o` has only bit WIDTH-1 set (0x80 for 8 bits) and `sout_o` is 0. `eoc_o` is 0 from the following falling edge, even if it was high before.
- R3: No start occurs while `sc_i` stays 1 across edges, or while `sc_i` is 0, with `mr_i` 0. In both cases the conversion in progress carries on. Once a conversion is complete, `q_o` and `eoc_o` hold.
- R4: After `mr_i` is released while `sc_i` is 0, `q_o`, `sout_o` and `eoc_o` stay 0 until `sc_i` rises.
- R5: At each edge after a start, the current trial bit takes the value of `d_i` (1 keeps the bit, 0 clears it), and the next lower bit is set as the new trial. Decided bits hold. With an ideal comparator, `q_o` ends equal to the target code.
- R6: `eoc_o` rises on the falling edge that follows the rising edge deciding bit 0, which is the WIDTH-th rising edge after the start edge. It stays 0 before then.
- R7: In the clock period after the edge that decides bit i, `sout_o` equals that decision, so the word leaves MSB first. `sout_o` is 0 in the period after the start edge and in every period after bit 0 has been shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| sc_i | input | 1 | Start-convert request |
| mr_i | input | 1 | Synchronous master reset, active high |
| d_i | input | 1 | Comparator verdict for the current trial bit (1 = keep) |
| q_o | output | WIDTH | Parallel conversion word |
| eoc_o | output | 1 | End of conversion, updated on the falling edge |
| sout_o | output | 1 | Serial copy of each bit decision, MSB first |

## Verification
The hardest states to reach are the two start paths that depend on history. One is a start caused by releasing the master reset while the start input is already high. The other is a start input that drops and rises again in the middle of a conversion, which must restart it and not merely let it run on. The stimulus reaches both on purpose. It holds reset with the start input high, and then, in a separate sequence, releases reset with the start input low for several clocks before raising it. It also breaks into a conversion after three decisions with a one-cycle low on the start input. Full conversions run against an ideal comparator model of fixed and random targets. A scoreboard compares each serial bit with the target, MSB first.

// File: rtl/sar_pkg.sv
package sar_pkg;
   // control action chosen for one rising edge
   typedef enum logic [1:0] {
      ACT_RUN   = 2'd0,
      ACT_START = 2'd1,
      ACT_CLEAR = 2'd2
   } sar_act_e;
endpackage

// File: rtl/sar_ctl_decode.sv
module sar_ctl_decode
   import sar_pkg::*;
(
   input  logic     clk,
   input  logic     sc_i,
   input  logic     mr_i,
   output sar_act_e act_o
);
   logic sc_prev;
   logic mr_prev;

   always_ff @(posedge clk) begin
      sc_prev <= sc_i;
      mr_prev <= mr_i;
   end

   // reset wins; start needs a fresh SC or a just-released MR
   always_comb begin
      if (mr_i)
         act_o = ACT_CLEAR;
      else if (sc_i && (!sc_prev || mr_prev))
         act_o = ACT_START;
      else
         act_o = ACT_RUN;
   end
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell
   import sar_pkg::*;
#(
   parameter bit IS_MSB = 1'b0
)(
   input  logic     clk,
   input  sar_act_e act_i,
   input  logic     trial_i,
   input  logic     arm_i,
   input  logic     d_i,
   output logic     q_o
);
   always_ff @(posedge clk) begin
      unique case (act_i)
         ACT_CLEAR: q_o <= 1'b0;
         ACT_START: q_o <= IS_MSB;
         default: begin
            if (trial_i)
               q_o <= d_i;
            else if (arm_i)
               q_o <= 1'b1;
         end
      endcase
   end

   // the bit on trial takes the comparator verdict
   assert_decide_follows_d_R5: assert property (@(posedge clk) disable iff (act_i == ACT_CLEAR)
      (act_i == ACT_RUN && trial_i) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
   import sar_pkg::*;
#(
   parameter int WIDTH = 8
)(
   input  logic             clk,
   input  sar_act_e         act_i,
   input  logic             d_i,
   output logic [WIDTH-1:0] trial_o,
   output logic             done_o,
   output logic             sout_o,
   output logic             eoc_o
);
   localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   always_ff @(posedge clk) begin
      unique case (act_i)
         ACT_CLEAR: begin
            trial_o <= '0;
            done_o  <= 1'b0;
            sout_o  <= 1'b0;
         end
         ACT_START: begin
            trial_o <= MSB_ONLY;
            done_o  <= 1'b0;
            sout_o  <= 1'b0;
         end
         default: begin
            trial_o <= trial_o >> 1;
            sout_o  <= (|trial_o) ? d_i : 1'b0;
            if (trial_o[0])
               done_o <= 1'b1;
         end
      endcase
   end

   // flag settles half a clock after the last decision
   always_ff @(negedge clk) begin
      eoc_o <= done_o;
   end

   assert_start_loads_msb_R2: assert property (@(posedge clk) disable iff (act_i == ACT_CLEAR)
      (act_i == ACT_START) |=> (trial_o == MSB_ONLY && !sout_o));

   assert_serial_quiet_R7: assert property (@(posedge clk) disable iff (act_i == ACT_CLEAR)
      (act_i == ACT_RUN && trial_o == '0) |=> !sout_o);
endmodule

// File: rtl/sar_cascade_reg.sv
module sar_cascade_reg
   import sar_pkg::*;
#(
   parameter int WIDTH = 8
)(
   input  logic             clk,
   input  logic             sc_i,
   input  logic             mr_i,
   input  logic             d_i,
   output logic [WIDTH-1:0] q_o,
   output logic             eoc_o,
   output logic             sout_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_cascade_reg: WIDTH must be at least 2");
      end
   endgenerate

   sar_act_e         act;
   logic [WIDTH-1:0] trial;
   logic [WIDTH-1:0] arm;
   logic             done;

   sar_ctl_decode i_decode (
      .clk   (clk),
      .sc_i  (sc_i),
      .mr_i  (mr_i),
      .act_o (act)
   );

   sar_sequencer #(.WIDTH(WIDTH)) i_seq (
      .clk     (clk),
      .act_i   (act),
      .d_i     (d_i),
      .trial_o (trial),
      .done_o  (done),
      .sout_o  (sout_o),
      .eoc_o   (eoc_o)
   );

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         if (gi == WIDTH - 1) begin : g_top
            assign arm[gi] = 1'b0;
         end else begin : g_low
            assign arm[gi] = trial[gi+1];
         end
         sar_bit_cell #(.IS_MSB(gi == WIDTH - 1)) i_cell (
            .clk     (clk),
            .act_i   (act),
            .trial_i (trial[gi]),
            .arm_i   (arm[gi]),
            .d_i     (d_i),
            .q_o     (q_o[gi])
         );
      end
   endgenerate

   assert_reset_clears_R1: assert property (@(posedge clk)
      mr_i |=> (q_o == '0 && !sout_o));

   assert_parked_after_release_R4: assert property (@(posedge clk) disable iff (mr_i)
      ($past(mr_i) && !sc_i) |=> (q_o == '0));

   assert_hold_when_done_R3: assert property (@(posedge clk) disable iff (mr_i)
      (done && act == ACT_RUN) |=> $stable(q_o));

   assert_eoc_means_done_R6: assert property (@(posedge clk) disable iff (mr_i)
      eoc_o |-> done);
endmodule

// File: tb/test_sar_cascade_reg.sv
module test_sar_cascade_reg;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   logic         clk = 1'b0;
   logic         sc  = 1'b0;
   logic         mr  = 1'b1;
   logic         d   = 1'b0;
   logic [W-1:0] q;
   logic         eoc;
   logic         sout;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  ended  = 1'b0;
   bit  exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   sar_cascade_reg #(.WIDTH(W)) i_sar_cascade_reg (
      .clk(clk), .sc_i(sc), .mr_i(mr), .d_i(d),
      .q_o(q), .eoc_o(eoc), .sout_o(sout)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   // monitor: pops one expected serial bit per period while items wait
   always begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         chk(sout == e, "R7 serial bit", int'(sout), int'(e));
      end
   end

   // driver: one full conversion against an ideal comparator
   task automatic conv(input logic [W-1:0] tgt, input bit pulse);
      sc = 1'b0; mr = 1'b0;
      tick();
      sc = 1'b1;
      tick();
      chk(q == 8'h80, "R2 start word", int'(q), 8'h80);
      chk(sout == 1'b0, "R7 inhibit first period", int'(sout), 0);
      chk(eoc == 1'b0, "R2 eoc dropped", int'(eoc), 0);
      if (pulse) sc = 1'b0;
      d = (q <= tgt);
      #2;
      for (int i = W - 1; i >= 0; i--) exp_q.push_back(tgt[i]);
      for (int c = 0; c < W; c++) begin
         tick();
         if (c == W - 2) chk(eoc == 1'b0, "R6 eoc not early", int'(eoc), 0);
         if (c < W - 1) d = (q <= tgt);
      end
      chk(eoc == 1'b1, "R6 eoc rise", int'(eoc), 1);
      chk(q == tgt, "R5 result", int'(q), int'(tgt));
      tick();
      chk(q == tgt, "R3 result holds", int'(q), int'(tgt));
      chk(eoc == 1'b1, "R3 eoc holds", int'(eoc), 1);
      chk(sout == 1'b0, "R7 quiet after word", int'(sout), 0);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!ended) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      chk(q == 0, "R1 reset q", int'(q), 0);
      chk(sout == 0, "R1 reset sout", int'(sout), 0);
      chk(eoc == 0, "R1 reset eoc", int'(eoc), 0);

      // R4: release with SC low stays parked
      mr = 1'b0; sc = 1'b0;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk(q == 0 && sout == 0 && eoc == 0, "R4 parked", int'(q), 0);
      end
      sc = 1'b1;
      tick();
      chk(q == 8'h80, "R4 start on SC rise", int'(q), 8'h80);

      // R1 mid-conversion with SC high
      d = 1'b1;
      tick();
      mr = 1'b1;
      tick();
      chk(q == 0, "R1 clear mid-run", int'(q), 0);
      chk(sout == 0, "R1 clear sout", int'(sout), 0);

      // R2: release of MR while SC already high starts
      mr = 1'b0;
      tick();
      chk(q == 8'h80, "R2 start on MR release", int'(q), 8'h80);

      // R3/R2: SC low mid-run continues, then SC rise restarts
      d = 1'b1;
      tick();
      tick();
      chk(q == 8'hE0, "R5 two kept bits", int'(q), 8'hE0);
      sc = 1'b0; d = 1'b0;
      tick();
      chk(q == 8'hD0, "R3 continues with SC low", int'(q), 8'hD0);
      sc = 1'b1;
      tick();
      chk(q == 8'h80, "R2 restart mid-run", int'(q), 8'h80);

      conv(8'h00, 1'b0);
      conv(8'hFF, 1'b1);
      conv(8'hA5, 1'b0);
      conv(8'h5A, 1'b1);
      conv(8'h01, 1'b0);
      conv(8'h80, 1'b1);
      for (int r = 0; r < 6; r++) conv(8'($urandom), r[0]);

      mr = 1'b1;
      tick();
      tick();
      chk(eoc == 0, "R1 eoc cleared", int'(eoc), 0);

      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule